// File: doc/BRIEF.md
# Ping-Pong Transmit Endpoint FIFO

This block buffers outgoing packets for a bulk IN endpoint using two equal banks. The processor fills one bank a byte at a time while the serial-bus side streams the other bank to the host. A trigger from the processor hands the filled bank to the bus side and moves further writes to the opposite bank. Only one bank can wait for, or be in, transmission at a time, so packets leave in the order they were committed.

The bus side sees whether a packet is on offer and how many bytes it holds. It pulls the bytes out one per request, and it releases the bank with an acknowledge once the host has taken the packet. A clear command discards whatever the processor has loaded and any committed packet whose sending has not begun. A bank already being sent is left untouched.

Top module: `pingpong_tx_fifo`

## Requirements
- R1: After a synchronous reset, `swap_ok` is 1, while `tx_avail`, `ovf_flag`, `rd_valid`, `wr_level` and `tx_count` are all 0.
- R2: Each `wr_valid` cycle without `fifo_clear` stores `wr_data` in the processor's bank and raises `wr_level` by one, but only while `wr_level` is below MAX_PKT. `wr_level` never exceeds MAX_PKT.
- R3: A write while `wr_level` equals MAX_PKT is dropped and leaves `wr_level` unchanged. It sets `ovf_flag`, which stays 1 until the next `fifo_clear` or reset.
- R4: `pkt_commit` while `swap_ok` is 1 gives the following results in the next cycle: `tx_avail` is 1, `tx_count` equals the number of bytes written to that bank (zero allowed), and `wr_level` is 0.
- R5: `pkt_commit` while `swap_ok` is 0 is ignored. `swap_ok` stays 0, the offered packet and its `tx_count` are unchanged, and the processor keeps filling the same bank.
- R6: `rd_en` while a packet is offered and unread bytes remain returns the next byte in write order on `rd_data`, with `rd_valid` set in the cycle after the request. Requests beyond `tx_count`, or made with no packet offered, give no `rd_valid`.
- R7: `pkt_ack` while `tx_avail` is 1 frees the bank. In the next cycle `tx_avail` is 0, `tx_count` is 0 and `swap_ok` is 1.
- R8: `fifo_clear` sets `wr_level` and `ovf_flag` to 0. It also discards a committed packet from which no byte has yet been read, so `tx_avail` drops to 0.
- R9: `fifo_clear` does not disturb a packet from which at least one byte has been read. `tx_avail` and `tx_count` are kept, and later reads continue from where they stopped.
- R10: `fifo_clear` in the same cycle as a write or a trigger wins, and the write and trigger are ignored. `pkt_ack` in the same cycle as `rd_en` wins, and no byte is returned.
- R11: A write in the same cycle as an accepted `pkt_commit` is stored before the hand-over and counts as the last byte of that packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Processor byte write strobe |
| wr_data | input | DATA_W | Processor write byte |
| pkt_commit | input | 1 | Packet-enable trigger: hand the current bank to the bus side |
| fifo_clear | input | 1 | Discard processor bank and any not-yet-started packet |
| wr_level | output | LEN_W | Bytes loaded into the processor's bank |
| swap_ok | output | 1 | Alternate bank free; a trigger would be accepted |
| ovf_flag | output | 1 | Sticky: a write was dropped |
| tx_avail | output | 1 | A committed packet is offered to the bus side |
| tx_count | output | LEN_W | Byte count of the offered packet |
| rd_en | input | 1 | Bus side requests the next byte |
| rd_valid | output | 1 | `rd_data` holds a requested byte |
| rd_data | output | DATA_W | Byte returned to the bus side |
| pkt_ack | input | 1 | Host acknowledged the offered packet |

## Verification
The bench builds the block with DATA_W = 8 and MAX_PKT = 8. With eight-byte banks, a full bank is reached within a handful of cycles. That allows the full-bank drop, the sticky overflow flag and full-length reads to be exercised many times over. The small bank also lets a long random run of writes, triggers, reads, acknowledges and clears reach every collision: clear against each bank state, ack against read, and trigger against write. Each of these is compared cycle by cycle against a queue-based model.

// File: rtl/pptx_pkg.sv
package pptx_pkg;
  // State of the bank owned by the bus side
  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,  // empty, free for the processor
    BK_READY = 2'd1,  // committed, no byte read yet
    BK_SEND  = 2'd2   // at least one byte handed to the bus side
  } bank_st_t;
endpackage

// File: rtl/pptx_ram.sv
module pptx_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual-port, registered read: maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pptx_bank_ctl.sv
module pptx_bank_ctl import pptx_pkg::*; #(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             is_cpu,
  input  logic             wr_go,
  input  logic             commit_go,
  input  logic             clear_go,
  input  logic             rd_go,
  input  logic             ack_go,
  output bank_st_t         st,
  output logic [LEN_W-1:0] len
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= BK_IDLE;
      len <= '0;
    end else if (is_cpu) begin
      if (clear_go) begin
        len <= '0;
      end else begin
        if (wr_go)     len <= len + 1'b1;
        if (commit_go) st  <= BK_READY;
      end
    end else begin
      if (ack_go) begin
        st  <= BK_IDLE;
        len <= '0;
      end else if (clear_go && st == BK_READY) begin
        st  <= BK_IDLE;
        len <= '0;
      end else if (rd_go) begin
        st <= BK_SEND;
      end
    end
  end
endmodule

// File: rtl/pingpong_tx_fifo.sv
module pingpong_tx_fifo import pptx_pkg::*; #(
  parameter int DATA_W  = 8,
  parameter int MAX_PKT = 64,
  localparam int LEN_W  = $clog2(MAX_PKT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pkt_commit,
  input  logic              fifo_clear,
  output logic [LEN_W-1:0]  wr_level,
  output logic              swap_ok,
  output logic              ovf_flag,
  output logic              tx_avail,
  output logic [LEN_W-1:0]  tx_count,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pkt_ack
);
  localparam int PTR_W  = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1;
  localparam int ADDR_W = PTR_W + 1;
  localparam logic [LEN_W-1:0] FULL = LEN_W'(MAX_PKT);

  logic             cpu_bank;
  logic             usb_bank;
  bank_st_t         st  [2];
  logic [LEN_W-1:0] len [2];
  logic [LEN_W-1:0] rd_ptr;
  logic             ovf_q;
  logic             rv_q;

  bank_st_t         usb_st;
  logic [LEN_W-1:0] usb_len;
  logic [LEN_W-1:0] cpu_len;
  logic             wr_go, commit_go, ack_go, drop_ready, rd_go;

  assign usb_bank = ~cpu_bank;
  assign usb_st   = st[usb_bank];
  assign usb_len  = len[usb_bank];
  assign cpu_len  = len[cpu_bank];

  // Qualified events
  assign wr_go      = wr_valid && !fifo_clear && (cpu_len < FULL);
  assign commit_go  = pkt_commit && !fifo_clear && (usb_st == BK_IDLE);
  assign ack_go     = pkt_ack && (usb_st != BK_IDLE);
  assign drop_ready = fifo_clear && (usb_st == BK_READY);
  assign rd_go      = rd_en && !pkt_ack && !drop_ready &&
                      (usb_st != BK_IDLE) && (rd_ptr < usb_len);

  for (genvar g = 0; g < 2; g++) begin : g_bank
    pptx_bank_ctl #(.LEN_W(LEN_W)) u_ctl (
      .clk       (clk),
      .rst       (rst),
      .is_cpu    (cpu_bank == 1'(g)),
      .wr_go     (wr_go),
      .commit_go (commit_go),
      .clear_go  (fifo_clear),
      .rd_go     (rd_go),
      .ack_go    (ack_go),
      .st        (st[g]),
      .len       (len[g])
    );
  end

  pptx_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (wr_go),
    .waddr ({cpu_bank, cpu_len[PTR_W-1:0]}),
    .wdata (wr_data),
    .re    (rd_go),
    .raddr ({usb_bank, rd_ptr[PTR_W-1:0]}),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_bank <= 1'b0;
      rd_ptr   <= '0;
      ovf_q    <= 1'b0;
      rv_q     <= 1'b0;
    end else begin
      rv_q <= rd_go;
      if (commit_go) cpu_bank <= ~cpu_bank;

      if (ack_go || drop_ready || commit_go) rd_ptr <= '0;
      else if (rd_go)                        rd_ptr <= rd_ptr + 1'b1;

      if (fifo_clear)                ovf_q <= 1'b0;
      else if (wr_valid && !wr_go)   ovf_q <= 1'b1;
    end
  end

  assign wr_level = cpu_len;
  assign swap_ok  = (usb_st == BK_IDLE);
  assign tx_avail = (usb_st != BK_IDLE);
  assign tx_count = usb_len;
  assign ovf_flag = ovf_q;
  assign rd_valid = rv_q;
endmodule

// File: rtl/pptx_chk.sv
module pptx_chk #(
  parameter int MAX_PKT = 64,
  localparam int LEN_W  = $clog2(MAX_PKT + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_valid,
  input logic             pkt_commit,
  input logic             fifo_clear,
  input logic [LEN_W-1:0] wr_level,
  input logic             swap_ok,
  input logic             ovf_flag,
  input logic             tx_avail,
  input logic [LEN_W-1:0] tx_count,
  input logic             rd_en,
  input logic             rd_valid,
  input logic             pkt_ack
);
  localparam logic [LEN_W-1:0] FULL = LEN_W'(MAX_PKT);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (swap_ok && !tx_avail && !ovf_flag && !rd_valid &&
                    wr_level == '0 && tx_count == '0));

  a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
    wr_level <= FULL);

  a_r3_drop_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !fifo_clear && !pkt_commit && wr_level == FULL)
      |=> (ovf_flag && $stable(wr_level)));

  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !fifo_clear) |=> ovf_flag);

  a_r5_trigger_ignored: assert property (@(posedge clk) disable iff (rst)
    (pkt_commit && !swap_ok && !fifo_clear && !pkt_ack)
      |=> (tx_avail && !swap_ok && $stable(tx_count)));

  a_r6_valid_follows_read: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));

  a_r6_no_data_when_empty: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !tx_avail) |=> !rd_valid);

  a_r7_ack_frees: assert property (@(posedge clk) disable iff (rst)
    (pkt_ack && tx_avail) |=> (swap_ok && !tx_avail && tx_count == '0));

  a_r8_clear_empties: assert property (@(posedge clk) disable iff (rst)
    fifo_clear |=> (!ovf_flag && wr_level == '0));
endmodule

bind pingpong_tx_fifo pptx_chk #(.MAX_PKT(MAX_PKT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_valid   (wr_valid),
  .pkt_commit (pkt_commit),
  .fifo_clear (fifo_clear),
  .wr_level   (wr_level),
  .swap_ok    (swap_ok),
  .ovf_flag   (ovf_flag),
  .tx_avail   (tx_avail),
  .tx_count   (tx_count),
  .rd_en      (rd_en),
  .rd_valid   (rd_valid),
  .pkt_ack    (pkt_ack)
);

// File: tb/pingpong_tx_fifo_test.sv
module pingpong_tx_fifo_test;
  localparam int DW = 8;
  localparam int MP = 8;
  localparam int LW = $clog2(MP + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0, pkt_commit = 1'b0, fifo_clear = 1'b0;
  logic          rd_en = 1'b0, pkt_ack = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [LW-1:0] wr_level, tx_count;
  logic          swap_ok, ovf_flag, tx_avail, rd_valid;
  logic [DW-1:0] rd_data;

  always #5 clk = ~clk;

  pingpong_tx_fifo #(.DATA_W(DW), .MAX_PKT(MP)) uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .pkt_commit(pkt_commit), .fifo_clear(fifo_clear), .wr_level(wr_level),
    .swap_ok(swap_ok), .ovf_flag(ovf_flag), .tx_avail(tx_avail),
    .tx_count(tx_count), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_data(rd_data), .pkt_ack(pkt_ack)
  );

  // Reference model
  logic [DW-1:0] cpu_q[$];
  logic [DW-1:0] tx_q[$];
  int            tstate;   // 0 empty, 1 committed, 2 sending
  int            rd_idx;
  bit            m_ovf, m_rv;
  logic [DW-1:0] m_rd;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  task automatic model();
    int pre_t;
    pre_t = tstate;
    m_rv  = 0;
    if (rst) begin
      cpu_q.delete(); tx_q.delete(); tstate = 0; rd_idx = 0; m_ovf = 0;
      return;
    end
    // bus side, on pre-cycle state
    if (pkt_ack && pre_t != 0) begin
      tx_q.delete(); tstate = 0; rd_idx = 0;
    end else if (rd_en && pre_t != 0 && !(fifo_clear && pre_t == 1) &&
                 rd_idx < tx_q.size()) begin
      m_rd = tx_q[rd_idx]; rd_idx++; m_rv = 1; tstate = 2;
    end
    if (fifo_clear) begin
      cpu_q.delete(); m_ovf = 0;
      if (pre_t == 1) begin tx_q.delete(); tstate = 0; rd_idx = 0; end
    end else begin
      if (wr_valid) begin
        if (cpu_q.size() < MP) cpu_q.push_back(wr_data);
        else m_ovf = 1;
      end
      if (pkt_commit && pre_t == 0) begin
        tx_q = cpu_q; cpu_q.delete(); tstate = 1; rd_idx = 0;
      end
    end
  endtask

  task automatic compare();
    chk("swap_ok",  int'(swap_ok),  int'(tstate == 0));
    chk("tx_avail", int'(tx_avail), int'(tstate != 0));
    chk("tx_count", int'(tx_count), tx_q.size());
    chk("wr_level", int'(wr_level), cpu_q.size());
    chk("ovf_flag", int'(ovf_flag), int'(m_ovf));
    chk("rd_valid", int'(rd_valid), int'(m_rv));
    if (m_rv) chk("rd_data", int'(rd_data), int'(m_rd));
  endtask

  task automatic step();
    @(posedge clk);
    model();
    @(negedge clk);
    compare();
    wr_valid = 0; pkt_commit = 0; fifo_clear = 0; rd_en = 0; pkt_ack = 0;
  endtask

  task automatic wr(input int b);
    wr_valid = 1; wr_data = DW'(b); step();
  endtask
  task automatic commit();  pkt_commit = 1; step(); endtask
  task automatic rd();      rd_en = 1;      step(); endtask
  task automatic ack();     pkt_ack = 1;    step(); endtask
  task automatic clr();     fifo_clear = 1; step(); endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL %s watchdog: actual=hung expected=finished", cur_req);
      summary();
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    rst = 1; step(); step(); rst = 0; step();

    // R2, R4, R6, R7: basic packet
    cur_req = "R2";
    for (int i = 0; i < 5; i++) wr(8'h10 + i);
    cur_req = "R4"; commit();
    cur_req = "R6";
    for (int i = 0; i < 7; i++) rd();
    cur_req = "R7"; ack(); step();

    // R11: write together with trigger
    cur_req = "R11";
    for (int i = 0; i < 3; i++) wr(8'h20 + i);
    wr_valid = 1; wr_data = 8'h2F; pkt_commit = 1; step();
    for (int i = 0; i < 5; i++) rd();

    // R5: trigger while alternate still pending
    cur_req = "R5";
    wr(8'h31); wr(8'h32); commit(); commit();
    ack(); commit();
    rd(); rd(); rd(); ack();

    // R3: full bank, dropped writes, sticky flag
    cur_req = "R3";
    for (int i = 0; i < MP + 2; i++) wr(8'h40 + i);
    step(); commit(); step();
    for (int i = 0; i < MP + 1; i++) rd();
    ack();

    // R8: clear discards loaded and unstarted data
    cur_req = "R8";
    wr(8'h51); wr(8'h52); commit(); wr(8'h53);
    for (int i = 0; i < MP + 1; i++) wr(8'h60);
    clr(); rd(); step();

    // R9: clear leaves a packet in flight
    cur_req = "R9";
    wr(8'h71); wr(8'h72); wr(8'h73); commit(); rd(); wr(8'h74);
    clr(); rd(); rd(); rd(); ack();

    // R10: clear beats write and trigger, ack beats read
    cur_req = "R10";
    wr(8'h81);
    wr_valid = 1; wr_data = 8'h82; pkt_commit = 1; fifo_clear = 1; step();
    wr(8'h83); commit();
    rd_en = 1; pkt_ack = 1; step();
    rd_en = 1; fifo_clear = 1; step();

    // R4: zero-length packet
    cur_req = "R4";
    commit(); rd(); ack();

    // Random mix of all events
    cur_req = "R6";
    for (int i = 0; i < 3000; i++) begin
      wr_valid   = ($urandom_range(0, 99) < 55);
      wr_data    = DW'($urandom);
      pkt_commit = ($urandom_range(0, 99) < 12);
      fifo_clear = ($urandom_range(0, 99) < 3);
      rd_en      = ($urandom_range(0, 99) < 50);
      pkt_ack    = ($urandom_range(0, 99) < 8);
      step();
    end

    done = 1;
    summary();
  end
endmodule